// File: doc/BRIEF.md
# Partitioned Bucket Receive Queue

This block is the receive side of one station on a message ring. A single shared message store is divided into as many as eight independent first-in first-out queues, called buckets. Software gives each bucket a size, and each bucket's region begins where the lower-numbered buckets end. Every arriving message names a target bucket and is appended to that bucket's region. The sender ID travels with the message in the store.

A consumer pops one message at a time from a bucket it selects. Every successful pop returns the payload and also emits a one-cycle credit-return pulse. The pulse carries the stored sender ID and the bucket number, so the original sender can reuse its credit. Each bucket has its own read pointer, write pointer and occupancy count, and both pointers wrap inside the bucket's region. Sticky flags report a bad configuration and any dropped write. A per-bucket vector shows which buckets are empty.

Top module: `bucket_rxq`

## Requirements
- R1: After reset, every bucket size is 0, `empty_vec` is all ones, and `rd_valid`, `cr_valid`, `ovf_flag` and `cfg_error` are 0.
- R2: A pop on a non-empty bucket returns that bucket's entries in the order they were written. `rd_valid` and `rd_data` are valid for exactly one cycle, after the clock edge that accepts the pop.
- R3: In the same cycle as `rd_valid`, `cr_valid` pulses for one cycle. `cr_sid` carries the sender ID stored with the entry and `cr_bkt` carries the bucket number.
- R4: Buckets are independent. Writes and pops interleaved across buckets never move data between buckets.
- R5: Both pointers wrap inside the bucket's region. Filling a bucket, partly draining it and refilling it keeps FIFO order.
- R6: A write to a bucket that already holds `size` entries is dropped. `ovf_flag` reads 1 after that edge and stays 1 until reset. The bucket still returns exactly its earlier entries.
- R7: A write to a bucket of size 0 is dropped and sets `ovf_flag`. The bucket stays empty.
- R8: A pop on an empty bucket is ignored. No `rd_valid` or `cr_valid` follows.
- R9: If the configured sizes add up to more than the store depth (256), `cfg_error` reads 1 after the second clock edge following the write. It then stays 1 until reset.
- R10: A non-zero size that is not a power of two raises `cfg_error` with the same timing as R9. So does a bucket whose start index (the sum of the lower buckets' sizes) is not a multiple of its own size. Sizes 32, 32, 64, 128 for buckets 0 to 3 are legal.
- R11: A configuration write is accepted only while every bucket is empty; otherwise it is ignored. An accepted write resets all pointers and counts.
- R12: Bit i of `empty_vec` is 1 exactly when bucket i holds no entries. The bit updates on the clock edge that performs the write or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Bucket whose size is written |
| cfg_size | input | 9 | New bucket size in entries (0 disables the bucket) |
| in_valid | input | 1 | Incoming message strobe |
| in_bkt | input | 3 | Target bucket of the incoming message |
| in_sid | input | 4 | Sender ID of the incoming message |
| in_data | input | 16 | Payload of the incoming message |
| pop_req | input | 1 | Pop request |
| pop_bkt | input | 3 | Bucket to pop from |
| rd_valid | output | 1 | Popped entry is on `rd_data` |
| rd_data | output | 16 | Payload of the popped entry |
| cr_valid | output | 1 | Credit-return pulse |
| cr_sid | output | 4 | Sender that gets the credit back |
| cr_bkt | output | 3 | Bucket the credit belongs to |
| empty_vec | output | 8 | Per-bucket empty status |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| cfg_error | output | 1 | Sticky configuration error flag |

## Verification
Pop results (`rd_valid`, `rd_data` and the credit fields) are due one edge after the pop is presented. `ovf_flag` and `empty_vec` also change on the edge that sees the write or pop. `cfg_error` is due on the second edge after a configuration write, because the size register sits in front of the check. The bench changes inputs one time unit after a rising edge and samples outputs at that same offset. One edge after a write or pop it reads the pop, overflow and empty results, and after two edges it reads the configuration flag. Every check therefore sees the edge that is due to produce its value.

// File: rtl/brq_pkg.sv
package brq_pkg;

  // True when a non-zero size is not a power of two.
  function automatic logic not_pow2(input logic [15:0] v);
    return (v != '0) && ((v & (v - 16'd1)) != '0);
  endfunction

endpackage

// File: rtl/brq_cfg.sv
module brq_cfg #(
  parameter int NB    = 8,
  parameter int DEPTH = 256,
  parameter int BW    = 3,
  parameter int AW    = 8,
  parameter int SZW   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [BW-1:0]     cfg_idx,
  input  logic [SZW-1:0]    cfg_size,
  input  logic              idle,
  output logic              cfg_load,
  output logic [NB*SZW-1:0] size_flat,
  output logic [NB*AW-1:0]  start_flat,
  output logic              cfg_error
);
  import brq_pkg::*;

  localparam int TW = SZW + BW;

  logic [SZW-1:0] size_q [NB];
  logic [TW-1:0]  pre    [NB+1];
  logic [NB-1:0]  bad_b;
  logic           over;
  logic           err_q;

  assign cfg_load = cfg_we && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) size_q[i] <= '0;
    end else if (cfg_load) begin
      size_q[cfg_idx] <= cfg_size;
    end
  end

  assign pre[0] = '0;

  // Prefix sum of sizes gives each bucket's start; alignment is checked per bucket.
  for (genvar i = 0; i < NB; i++) begin : g_chain
    logic [TW-1:0] sz_ext;
    assign sz_ext     = TW'(size_q[i]);
    assign pre[i+1]   = pre[i] + sz_ext;
    assign bad_b[i]   = (size_q[i] != '0) &&
                        (not_pow2(16'(size_q[i])) || ((pre[i] & (sz_ext - 1'b1)) != '0));
    assign size_flat[i*SZW +: SZW] = size_q[i];
    assign start_flat[i*AW +: AW]  = pre[i][AW-1:0];
  end

  assign over = pre[NB] > TW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | over | (|bad_b);
  end

  assign cfg_error = err_q;

endmodule

// File: rtl/brq_bucket.sv
module brq_bucket #(
  parameter int AW  = 8,
  parameter int SZW = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic [SZW-1:0] size,
  input  logic           push,
  input  logic           pop,
  output logic [AW-1:0]  wptr,
  output logic [AW-1:0]  rptr,
  output logic           full,
  output logic           empty
);
  logic [AW-1:0]  wp_q, rp_q;
  logic [SZW-1:0] cnt_q;
  logic [SZW-1:0] w_inc, r_inc;

  assign w_inc = {1'b0, wp_q} + 1'b1;
  assign r_inc = {1'b0, rp_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (w_inc == size) ? '0 : w_inc[AW-1:0];
      if (pop)  rp_q <= (r_inc == size) ? '0 : r_inc[AW-1:0];
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wptr  = wp_q;
  assign rptr  = rp_q;
  assign full  = (cnt_q == size);
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/brq_store.sv
module brq_store #(
  parameter int W     = 20,
  parameter int AW    = 8,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end

  assign rdata = q;

endmodule

// File: rtl/bucket_rxq.sv
module bucket_rxq #(
  parameter int NB     = 8,
  parameter int DEPTH  = 256,
  parameter int SID_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [$clog2(NB)-1:0]      cfg_idx,
  input  logic [$clog2(DEPTH):0]     cfg_size,
  input  logic                       in_valid,
  input  logic [$clog2(NB)-1:0]      in_bkt,
  input  logic [SID_W-1:0]           in_sid,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       pop_req,
  input  logic [$clog2(NB)-1:0]      pop_bkt,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       cr_valid,
  output logic [SID_W-1:0]           cr_sid,
  output logic [$clog2(NB)-1:0]      cr_bkt,
  output logic [NB-1:0]              empty_vec,
  output logic                       ovf_flag,
  output logic                       cfg_error
);
  localparam int BW  = $clog2(NB);
  localparam int AW  = $clog2(DEPTH);
  localparam int SZW = AW + 1;
  localparam int EW  = SID_W + DATA_W;

  logic [NB*SZW-1:0] size_flat;
  logic [NB*AW-1:0]  start_flat;
  logic              cfg_load;
  logic              idle;

  logic [AW-1:0] wptr_a [NB];
  logic [AW-1:0] rptr_a [NB];
  logic [AW-1:0] start_a [NB];
  logic [NB-1:0] full_v, empty_v;

  logic          push_ok, drop, pop_ok;
  logic [AW-1:0] waddr, raddr;
  logic [EW-1:0] rdata;
  logic          vld_q, ovf_q;
  logic [BW-1:0] bkt_q;

  assign idle = &empty_v;

  brq_cfg #(.NB(NB), .DEPTH(DEPTH), .BW(BW), .AW(AW), .SZW(SZW)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_size(cfg_size),
    .idle(idle), .cfg_load(cfg_load), .size_flat(size_flat), .start_flat(start_flat),
    .cfg_error(cfg_error)
  );

  assign push_ok = in_valid && !full_v[in_bkt];
  assign drop    = in_valid &&  full_v[in_bkt];
  assign pop_ok  = pop_req  && !empty_v[pop_bkt];

  for (genvar i = 0; i < NB; i++) begin : g_bkt
    assign start_a[i] = start_flat[i*AW +: AW];
    brq_bucket #(.AW(AW), .SZW(SZW)) bkt_i (
      .clk(clk), .rst(rst), .clear(cfg_load),
      .size(size_flat[i*SZW +: SZW]),
      .push(push_ok && (in_bkt == BW'(i))),
      .pop(pop_ok && (pop_bkt == BW'(i))),
      .wptr(wptr_a[i]), .rptr(rptr_a[i]),
      .full(full_v[i]), .empty(empty_v[i])
    );
  end

  assign waddr = start_a[in_bkt]  + wptr_a[in_bkt];
  assign raddr = start_a[pop_bkt] + rptr_a[pop_bkt];

  brq_store #(.W(EW), .AW(AW), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we(push_ok), .waddr(waddr), .wdata({in_sid, in_data}),
    .re(pop_ok), .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      bkt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= pop_ok;
      if (pop_ok) bkt_q <= pop_bkt;
      ovf_q <= ovf_q | drop;
    end
  end

  assign rd_valid  = vld_q;
  assign rd_data   = rdata[DATA_W-1:0];
  assign cr_valid  = vld_q;
  assign cr_sid    = rdata[EW-1:DATA_W];
  assign cr_bkt    = bkt_q;
  assign empty_vec = empty_v;
  assign ovf_flag  = ovf_q;

endmodule

// File: rtl/brq_chk.sv
module brq_chk #(
  parameter int NB  = 8,
  parameter int BW  = 3,
  parameter int SZW = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              in_valid,
  input logic [BW-1:0]     in_bkt,
  input logic              pop_req,
  input logic [BW-1:0]     pop_bkt,
  input logic              rd_valid,
  input logic              cr_valid,
  input logic [BW-1:0]     cr_bkt,
  input logic [NB-1:0]     empty_vec,
  input logic              ovf_flag,
  input logic              cfg_error,
  input logic [NB*SZW-1:0] size_flat
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (empty_vec == '1 && !rd_valid && !cr_valid && !ovf_flag && !cfg_error));

  // R2
  pop_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !empty_vec[pop_bkt]) |=> rd_valid);

  // R3
  credit_match_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (cr_valid && cr_bkt == $past(pop_bkt)));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty_vec[pop_bkt]) |=> !rd_valid);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R7
  zero_size_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_flat[in_bkt*SZW +: SZW] == '0) |=> ovf_flag);

  // R9
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_error |=> cfg_error);

  // R12
  push_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_we && size_flat[in_bkt*SZW +: SZW] != '0) |=> !empty_vec[$past(in_bkt)]);

endmodule

bind bucket_rxq brq_chk #(.NB(NB), .BW(BW), .SZW(SZW)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .in_valid(in_valid), .in_bkt(in_bkt),
  .pop_req(pop_req), .pop_bkt(pop_bkt), .rd_valid(rd_valid), .cr_valid(cr_valid),
  .cr_bkt(cr_bkt), .empty_vec(empty_vec), .ovf_flag(ovf_flag), .cfg_error(cfg_error),
  .size_flat(size_flat)
);

// File: tb/bucket_rxq_tb_top.sv
module bucket_rxq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [8:0]  cfg_size;
  logic        in_valid;
  logic [2:0]  in_bkt;
  logic [3:0]  in_sid;
  logic [15:0] in_data;
  logic        pop_req;
  logic [2:0]  pop_bkt;
  logic        rd_valid, cr_valid, ovf_flag, cfg_error;
  logic [15:0] rd_data;
  logic [3:0]  cr_sid;
  logic [2:0]  cr_bkt;
  logic [7:0]  empty_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bucket_rxq dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_size(cfg_size),
    .in_valid(in_valid), .in_bkt(in_bkt), .in_sid(in_sid), .in_data(in_data),
    .pop_req(pop_req), .pop_bkt(pop_bkt), .rd_valid(rd_valid), .rd_data(rd_data),
    .cr_valid(cr_valid), .cr_sid(cr_sid), .cr_bkt(cr_bkt), .empty_vec(empty_vec),
    .ovf_flag(ovf_flag), .cfg_error(cfg_error)
  );

  typedef struct packed {
    logic        is_pop;
    logic [2:0]  bkt;
    logic [3:0]  sid;
    logic [15:0] data;
    logic        ev;
  } vec_t;

  // Pushes carry sid/data; pops carry the expected sid/data and validity.
  localparam vec_t VEC [12] = '{
    '{1'b0, 3'd0, 4'd1, 16'hA001, 1'b0},
    '{1'b0, 3'd1, 4'd2, 16'hB001, 1'b0},
    '{1'b0, 3'd0, 4'd3, 16'hA002, 1'b0},
    '{1'b0, 3'd3, 4'd4, 16'hD001, 1'b0},
    '{1'b1, 3'd0, 4'd1, 16'hA001, 1'b1},
    '{1'b1, 3'd2, 4'd0, 16'h0000, 1'b0},
    '{1'b1, 3'd1, 4'd2, 16'hB001, 1'b1},
    '{1'b1, 3'd0, 4'd3, 16'hA002, 1'b1},
    '{1'b1, 3'd0, 4'd0, 16'h0000, 1'b0},
    '{1'b1, 3'd3, 4'd4, 16'hD001, 1'b1},
    '{1'b0, 3'd2, 4'd5, 16'hC001, 1'b0},
    '{1'b1, 3'd2, 4'd5, 16'hC001, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [8:0] sz);
    cfg_we = 1'b1; cfg_idx = idx; cfg_size = sz;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic configure();
    cfg_write(3'd0, 9'd32);
    cfg_write(3'd1, 9'd32);
    cfg_write(3'd2, 9'd64);
    cfg_write(3'd3, 9'd128);
  endtask

  task automatic push(input logic [2:0] b, input logic [3:0] s, input logic [15:0] d);
    in_valid = 1'b1; in_bkt = b; in_sid = s; in_data = d;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [2:0] b, input logic ev,
                         input logic [3:0] s, input logic [15:0] d);
    pop_req = 1'b1; pop_bkt = b;
    tick();
    pop_req = 1'b0;
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'(ev));
    chk({tag, " cr_valid"}, 32'(cr_valid), 32'(ev));
    if (ev) begin
      chk({tag, " rd_data"}, 32'(rd_data), 32'(d));
      chk({tag, " cr_sid"},  32'(cr_sid),  32'(s));
      chk({tag, " cr_bkt"},  32'(cr_bkt),  32'(b));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_we = 0; cfg_idx = 0; cfg_size = 0;
    in_valid = 0; in_bkt = 0; in_sid = 0; in_data = 0;
    pop_req = 0; pop_bkt = 0;
    #1;
    do_reset();

    // R1 reset state
    chk("R1 empty_vec", 32'(empty_vec), 32'hFF);
    chk("R1 rd_valid",  32'(rd_valid),  0);
    chk("R1 ovf_flag",  32'(ovf_flag),  0);
    chk("R1 cfg_error", 32'(cfg_error), 0);

    // R7 write to an unconfigured (size 0) bucket
    push(3'd5, 4'd1, 16'h1234);
    chk("R7 ovf_flag", 32'(ovf_flag), 1);
    chk("R7 empty_vec", 32'(empty_vec), 32'hFF);
    pop_chk("R7 pop zero bucket", 3'd5, 1'b0, 4'd0, 16'h0);

    // Legal configuration, then table walk (R2 R3 R4 R8)
    do_reset();
    configure();
    tick();
    chk("R10 legal cfg", 32'(cfg_error), 0);
    foreach (VEC[i]) begin
      if (VEC[i].is_pop)
        pop_chk($sformatf("R2 R3 R4 R8 vec%0d", i), VEC[i].bkt, VEC[i].ev, VEC[i].sid, VEC[i].data);
      else
        push(VEC[i].bkt, VEC[i].sid, VEC[i].data);
    end
    chk("R12 all empty after walk", 32'(empty_vec), 32'hFF);
    chk("R6 no overflow in walk", 32'(ovf_flag), 0);

    // R5 / R6 wrap and full in bucket 1 (32 entries), bucket 0 holds a marker
    push(3'd0, 4'd9, 16'h5A5A);
    chk("R12 bucket0 nonempty", 32'(empty_vec), 32'hFE);
    for (int i = 0; i < 32; i++) push(3'd1, 4'(i), 16'h0100 + 16'(i));
    chk("R6 no ovf at exactly full", 32'(ovf_flag), 0);
    push(3'd1, 4'hF, 16'hDEAD);
    chk("R6 ovf on full", 32'(ovf_flag), 1);
    for (int i = 0; i < 16; i++)
      pop_chk("R5 first drain", 3'd1, 1'b1, 4'(i), 16'h0100 + 16'(i));
    for (int i = 0; i < 16; i++) push(3'd1, 4'(i), 16'h0200 + 16'(i));
    for (int i = 16; i < 32; i++)
      pop_chk("R5 R6 after wrap old", 3'd1, 1'b1, 4'(i), 16'h0100 + 16'(i));
    for (int i = 0; i < 16; i++)
      pop_chk("R5 after wrap new", 3'd1, 1'b1, 4'(i), 16'h0200 + 16'(i));
    pop_chk("R8 bucket1 drained", 3'd1, 1'b0, 4'd0, 16'h0);
    pop_chk("R4 bucket0 untouched", 3'd0, 1'b1, 4'd9, 16'h5A5A);
    chk("R6 ovf sticky", 32'(ovf_flag), 1);

    // R11 configuration write while not idle is ignored
    do_reset();
    configure();
    push(3'd0, 4'd7, 16'hCAFE);
    cfg_write(3'd0, 9'd0);
    tick();
    chk("R11 bucket0 still nonempty", 32'(empty_vec[0]), 0);
    pop_chk("R11 entry survives", 3'd0, 1'b1, 4'd7, 16'hCAFE);
    chk("R11 no cfg error", 32'(cfg_error), 0);

    // R9 total above depth
    do_reset();
    cfg_write(3'd0, 9'd128);
    cfg_write(3'd1, 9'd128);
    chk("R9 exactly full depth ok", 32'(cfg_error), 0);
    cfg_write(3'd2, 9'd128);
    tick();
    chk("R9 oversize total", 32'(cfg_error), 1);
    tick();
    chk("R9 sticky", 32'(cfg_error), 1);

    // R10 misaligned start
    do_reset();
    cfg_write(3'd0, 9'd32);
    cfg_write(3'd1, 9'd64);
    tick();
    chk("R10 misaligned start", 32'(cfg_error), 1);

    // R10 non power of two size
    do_reset();
    cfg_write(3'd0, 9'd48);
    chk("R10 flag not yet due", 32'(cfg_error), 0);
    tick();
    chk("R10 non pow2 size", 32'(cfg_error), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule